// File: doc/BRIEF.md
# Width-Matching FIFO Buffer

This block is a single-clock FIFO that joins a 36-bit port to an 18-bit port. A static mode input selects the direction. In wide-to-narrow mode, the writer pushes 36-bit words and the reader pops 18-bit halves. In narrow-to-wide mode, the writer pushes 18-bit halves, and the reader sees a 36-bit word only once both halves of it are stored. A static order input picks whether the low or the high half of each wide word travels first, in both directions.

Storage is counted in wide entries, and the depth is a parameter. The wide side carries a 32-bit payload, so the top four bits of every wide word are forced to zero. To keep throughput equal, the narrow side runs at twice the word rate of the wide side. A writer on one side of a bus, or a reader on the other, uses the block to match the two widths without any glue logic. The mode and order inputs may change only while the FIFO is drained; a change of mode needs a reset.

Top module: `wmf_fifo`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0 and `rd_data_o` is all zero.
- R2: Bits 35:32 of every wide word are taken as zero. These bits are dropped from a wide write and read back as zero on a wide read, whatever data the writer supplies.
- R3: In wide-to-narrow mode (`mode_i`=0) with `hi_first_i`=0, each stored word leaves as two reads. The first read returns bits 17:0 and the second read returns bits 35:18. Both appear on `rd_data_o[17:0]`, with `rd_data_o[35:18]` at zero, in the cycle after the accepted read.
- R4: In wide-to-narrow mode with `hi_first_i`=1, the first read of a word returns bits 35:18 and the second read returns bits 17:0.
- R5: In wide-to-narrow mode, a word stays counted until its second half has been read. `empty_o` stays 0 after the first half of the last word is read, and goes to 1 after the second half.
- R6: In narrow-to-wide mode (`mode_i`=1), two accepted writes of `wr_data_i[17:0]` form one word. With `hi_first_i`=0, the first write fills bits 17:0 and the second fills bits 35:18. With `hi_first_i`=1, the first write fills bits 35:18 and the second fills bits 17:0. A read returns the whole word, subject to R2, in the cycle after it is accepted.
- R7: In narrow-to-wide mode, `empty_o` stays 1 after a single narrow write into an empty FIFO, and falls only after the second half has been written.
- R8: `full_o` is 1 exactly when DEPTH wide words are stored. A write while full is ignored and changes neither the data nor the order of later reads.
- R9: A read while `empty_o` is 1 is ignored, and `rd_data_o` keeps its value.
- R10: Order is preserved when reads and writes happen in the same cycle, including a 2:1 stream in which the narrow side transfers every cycle and the wide side every other cycle.
- R11: `rd_data_o` changes only in the cycle after an accepted read, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: wide writes and narrow reads; 1: narrow writes and wide reads |
| hi_first_i | input | 1 | 1: the high half of a word is transferred first |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 36 | Write data; in narrow-to-wide mode only bits 17:0 are used |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | 36 | Registered read data; narrow reads use bits 17:0 |
| full_o | output | 1 | DEPTH wide words stored |
| empty_o | output | 1 | No complete wide word stored |

## Verification
The assertions check, on every cycle, the properties that do not depend on the data itself:
- the flags never assert together;
- the flags do not change without a request that could change them;
- the read data holds without an accepted read;
- the zero top bits on the wide side;
- the zero upper half on narrow reads.

Which half leaves first, how two narrow writes pack into one word, and whether order survives under full, empty and simultaneous traffic can be shown only by the bench's scenarios, which compare every read against a queue model.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
  typedef enum logic {
    MODE_W2N = 1'b0,
    MODE_N2W = 1'b1
  } wmf_mode_e;
endpackage

// File: rtl/wmf_ptr_ctrl.sv
module wmf_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_nx, rd_ptr_nx;
  logic [CNT_W-1:0] cnt_q;

  // wrap style chosen by depth
  if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
    assign wr_ptr_nx = wr_ptr_q + 1'b1;
    assign rd_ptr_nx = rd_ptr_q + 1'b1;
  end else begin : g_mod
    assign wr_ptr_nx = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    assign rd_ptr_nx = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_nx;
      if (pop_i)  rd_ptr_q <= rd_ptr_nx;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign full_o   = (cnt_q == CNT_W'(DEPTH));
  assign empty_o  = (cnt_q == '0);
endmodule

// File: rtl/wmf_store.sv
module wmf_store #(
  parameter int DEPTH  = 16,
  parameter int WIDE_W = 36,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [WIDE_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [WIDE_W-1:0] rdata_o
);
  logic [WIDE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/wmf_pack.sv
module wmf_pack
  import wmf_pkg::*;
#(
  parameter int WIDE_W    = 36,
  parameter int PAYLOAD_W = 32,
  localparam int NARROW_W = WIDE_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wmf_mode_e         mode_i,
  input  logic              hi_first_i,
  input  logic              wr_fire_i,
  input  logic [WIDE_W-1:0] wr_data_i,
  output logic              push_o,
  output logic [WIDE_W-1:0] entry_o
);
  localparam logic [WIDE_W-1:0] PAY_MASK =
    {{(WIDE_W - PAYLOAD_W){1'b0}}, {PAYLOAD_W{1'b1}}};

  logic                half_q;
  logic [NARROW_W-1:0] part_q;
  logic [WIDE_W-1:0]   entry;

  always_comb begin
    if (mode_i == MODE_N2W) begin
      push_o = wr_fire_i && half_q;
      entry  = hi_first_i ? {part_q, wr_data_i[NARROW_W-1:0]}
                          : {wr_data_i[NARROW_W-1:0], part_q};
    end else begin
      push_o = wr_fire_i;
      entry  = wr_data_i;
    end
    entry_o = entry & PAY_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      part_q <= '0;
    end else if (mode_i == MODE_N2W && wr_fire_i) begin
      half_q <= !half_q;
      if (!half_q) part_q <= wr_data_i[NARROW_W-1:0];
    end
  end
endmodule

// File: rtl/wmf_unpack.sv
module wmf_unpack
  import wmf_pkg::*;
#(
  parameter int WIDE_W = 36,
  localparam int NARROW_W = WIDE_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wmf_mode_e         mode_i,
  input  logic              hi_first_i,
  input  logic              rd_fire_i,
  input  logic [WIDE_W-1:0] head_i,
  output logic              pop_o,
  output logic [WIDE_W-1:0] rd_data_o
);
  logic                half_q;
  logic [WIDE_W-1:0]   data_q, data_nx;
  logic [NARROW_W-1:0] first_h, second_h;

  assign first_h  = hi_first_i ? head_i[WIDE_W-1:NARROW_W] : head_i[NARROW_W-1:0];
  assign second_h = hi_first_i ? head_i[NARROW_W-1:0] : head_i[WIDE_W-1:NARROW_W];

  always_comb begin
    if (mode_i == MODE_W2N) begin
      pop_o   = rd_fire_i && half_q;
      data_nx = {{(WIDE_W - NARROW_W){1'b0}}, half_q ? second_h : first_h};
    end else begin
      pop_o   = rd_fire_i;
      data_nx = head_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      data_q <= '0;
    end else if (rd_fire_i) begin
      data_q <= data_nx;
      if (mode_i == MODE_W2N) half_q <= !half_q;
    end
  end

  assign rd_data_o = data_q;
endmodule

// File: rtl/wmf_fifo.sv
module wmf_fifo
  import wmf_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int WIDE_W    = 36,
  parameter int PAYLOAD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              hi_first_i,
  input  logic              wr_en_i,
  input  logic [WIDE_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WIDE_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  wmf_mode_e         mode;
  logic              full, empty, wr_fire, rd_fire, push, pop;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [WIDE_W-1:0] entry, head;

  assign mode    = wmf_mode_e'(mode_i);
  assign wr_fire = wr_en_i && !full;
  assign rd_fire = rd_en_i && !empty;

  wmf_pack #(.WIDE_W(WIDE_W), .PAYLOAD_W(PAYLOAD_W)) i_pack (
    .clk_i, .rst_ni, .mode_i(mode), .hi_first_i, .wr_fire_i(wr_fire),
    .wr_data_i, .push_o(push), .entry_o(entry)
  );

  wmf_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .full_o(full), .empty_o(empty)
  );

  wmf_store #(.DEPTH(DEPTH), .WIDE_W(WIDE_W)) i_store (
    .clk_i, .we_i(push), .waddr_i(wr_ptr), .wdata_i(entry),
    .raddr_i(rd_ptr), .rdata_o(head)
  );

  wmf_unpack #(.WIDE_W(WIDE_W)) i_unpack (
    .clk_i, .rst_ni, .mode_i(mode), .hi_first_i, .rd_fire_i(rd_fire),
    .head_i(head), .pop_o(pop), .rd_data_o
  );

  assign full_o  = full;
  assign empty_o = empty;
endmodule

// File: rtl/wmf_fifo_chk.sv
module wmf_fifo_chk #(
  parameter int WIDE_W    = 36,
  parameter int PAYLOAD_W = 32,
  localparam int NARROW_W = WIDE_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [WIDE_W-1:0] rd_data_o,
  input logic              full_o,
  input logic              empty_o
);
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R8
  AST_FULL_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_en_i) |=> full_o); // R8
  AST_EMPTY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !wr_en_i) |=> empty_o); // R7
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && !empty_o) |=> $stable(rd_data_o)); // R9
  AST_WIDE_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[WIDE_W-1:PAYLOAD_W] == '0); // R2
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && rd_en_i && !empty_o) |=> rd_data_o[WIDE_W-1:NARROW_W] == '0); // R3
endmodule

bind wmf_fifo wmf_fifo_chk #(.WIDE_W(WIDE_W), .PAYLOAD_W(PAYLOAD_W)) i_wmf_fifo_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .full_o(full_o), .empty_o(empty_o)
);

// File: tb/test_wmf_fifo.sv
module test_wmf_fifo;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode = 1'b0, hi_first = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic        full, empty;

  int checks = 0, errors = 0;
  logic [35:0] exp_q[$];
  logic        n_phase = 1'b0;
  logic [17:0] n_part = '0;
  string       tag_rd = "R3";

  always #4 clk = ~clk;

  wmf_fifo #(.DEPTH(DEPTH)) i_wmf_fifo (
    .clk_i(clk), .rst_ni, .mode_i(mode), .hi_first_i(hi_first),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .full_o(full), .empty_o(empty)
  );

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver side: expected items into the scoreboard
  task automatic model_write(input logic [35:0] d);
    logic [35:0] m;
    if (!mode) begin
      m = d & 36'h0_FFFF_FFFF;
      if (hi_first) begin
        exp_q.push_back({18'b0, m[35:18]});
        exp_q.push_back({18'b0, m[17:0]});
      end else begin
        exp_q.push_back({18'b0, m[17:0]});
        exp_q.push_back({18'b0, m[35:18]});
      end
    end else if (!n_phase) begin
      n_part  = d[17:0];
      n_phase = 1'b1;
    end else begin
      m = hi_first ? {n_part, d[17:0]} : {d[17:0], n_part};
      exp_q.push_back(m & 36'h0_FFFF_FFFF);
      n_phase = 1'b0;
    end
  endtask

  // one clock: drive at negedge, monitor compares at the next negedge
  task automatic step(input logic wr, input logic [35:0] wd, input logic rd);
    logic        acc_w, acc_r;
    logic [35:0] prev, exp;
    int          entries;
    wr_en = wr; wr_data = wd; rd_en = rd;
    acc_w = wr && !full;
    acc_r = rd && !empty;
    prev  = rd_data;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (acc_r) begin
      if (exp_q.size() == 0) chk(1'b0, tag_rd, rd_data, 'x);
      else begin
        exp = exp_q.pop_front();
        chk(rd_data === exp, tag_rd, rd_data, exp);
      end
    end else begin
      chk(rd_data === prev, (rd && empty) ? "R9" : "R11", rd_data, prev);
    end
    if (acc_w) model_write(wd);
    entries = mode ? exp_q.size() : (exp_q.size() + 1) / 2;
    chk(empty === (entries == 0), mode ? "R7" : "R5", 36'(empty), 36'(entries == 0));
    chk(full === (entries == DEPTH), "R8", 36'(full), 36'(entries == DEPTH));
  endtask

  task automatic do_reset(input logic m, input logic h);
    @(negedge clk);
    rst_ni = 1'b0; mode = m; hi_first = h;
    exp_q.delete(); n_phase = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [35:0] pat(input int i);
    return 36'(64'h9E37_79B9_7F4A_7C15 * (i + 3)) ^ 36'(i);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(empty === 1'b1, "R1", 36'(empty), 36'd1);
    chk(full === 1'b0, "R1", 36'(full), 36'd0);
    chk(rd_data === '0, "R1", rd_data, '0);

    // R9: reads on empty FIFO
    tag_rd = "R9";
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1);

    // R3, R5: wide in, narrow out, low half first
    tag_rd = "R3";
    for (int i = 0; i < 3; i++) step(1'b1, pat(i), 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);

    // R2: top nibble set on the wide write
    tag_rd = "R2";
    step(1'b1, 36'hF_ABCD_1234, 1'b0);
    step(1'b1, 36'hA_FFFF_FFFF, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);

    // R4: high half first
    do_reset(1'b0, 1'b1);
    tag_rd = "R4";
    for (int i = 0; i < 4; i++) step(1'b1, pat(10 + i), 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b1);

    // R8: fill, overflow attempt, drain in order
    do_reset(1'b0, 1'b0);
    tag_rd = "R8";
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, pat(20 + i), 1'b0);
    for (int i = 0; i < 2 * DEPTH + 1; i++) step(1'b0, '0, 1'b1);

    // R10: wide write every other cycle, narrow read every cycle
    tag_rd = "R10";
    step(1'b1, pat(50), 1'b0);
    for (int i = 0; i < 40; i++) step(i[0] == 1'b1, pat(60 + i), 1'b1);

    // R6, R7: narrow in, wide out, low half first
    do_reset(1'b1, 1'b0);
    tag_rd = "R6";
    step(1'b1, 36'h0_0001_2345, 1'b0);
    step(1'b0, '0, 1'b1);
    step(1'b1, 36'hF_FFFF_FFFF, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, pat(100 + i), 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b1);

    // R6: high half first
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, pat(120 + i), 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);

    // R8: narrow fill, extra writes ignored
    do_reset(1'b1, 1'b0);
    tag_rd = "R8";
    for (int i = 0; i < 2 * DEPTH + 3; i++) step(1'b1, pat(140 + i), 1'b0);
    for (int i = 0; i < DEPTH + 1; i++) step(1'b0, '0, 1'b1);

    // R10: narrow write every cycle, wide read every other cycle
    do_reset(1'b1, 1'b0);
    tag_rd = "R10";
    for (int i = 0; i < 40; i++) step(1'b1, pat(200 + i), i[0] == 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule